// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Software reaches both through one 32-bit configuration dword with per-byte write enables. The platform side first binds the address of the device that occupies the slot, then signals attach and detach events for that address. The block sets the matching status bits and raises a one-cycle interrupt request when the enable bits allow it.

When software turns the power indicator off on an occupied slot, the block marks the slot empty and puts out a one-cycle removal strobe that carries the bound device's address. While the port is in a low-power state, an attach or detach event updates status at once but holds its hot-plug interrupt back. It sends a one-cycle wake request instead and delivers the interrupt when the port leaves low power. A parameter removes the slot entirely, which leaves a register pair that reads as zero and ignores everything.

Top module: `slot_hp_ctrl`

## Requirements
- R1: A read returns the status word in bits 31:16 and the control word in bits 15:0.
- R2: After reset the control word is 0x03C0, with both indicator fields (bits 9:8 and 7:6) at the off code 2'b11. The status word is zero, and irq_o, wake_o and rm_stb are low.
- R3: With SLOT_IMPL = 0 the dword reads zero. Control and status writes, binds and events have no effect, and no interrupt is raised.
- R4: A control write whose value differs from the stored one sets command-completed (status bit 4). A write of the same value does not set it. The change requests an interrupt if command-completed enable (control bit 4) is set.
- R5: A control write that moves the power-indicator field (bits 9:8) to 2'b11 from any other code, while presence-detect (status bit 6) is set, has four effects. It clears bit 6, sets presence-changed (bit 3), evaluates the hot-plug interrupt and pulses rm_stb for one cycle with rm_addr equal to the bound address. The binding is then dropped.
- R6: Writing one to status bits 0, 1, 3, 4 or 8 clears that bit. Writing zero, or writing to any other status bit (including presence-detect, bit 6), changes nothing.
- R7: An accepted attach sets status bits 6, 3 and 0. An accepted detach sets only bits 3 and 0.
- R8: A hot-plug interrupt is requested only when hot-plug enable (control bit 5) is set and either button-pressed (status bit 0) with its enable (control bit 0) or presence-changed (status bit 3) with its enable (control bit 3) is set.
- R9: bind_en records bind_addr for the slot. Attach and detach events are accepted only when a binding exists and evt_addr equals the bound address.
- R10: A control write needs both cfg_wr_be[1:0] set and a status write needs both cfg_wr_be[3:2] set. A narrower write to either half is dropped.
- R11: irq_o is a one-cycle pulse, registered in the cycle after the triggering write or event, and it is suppressed while msi_en is low.
- R12: An event accepted while low_power is high pulses wake_o for one cycle and holds back its hot-plug interrupt. The first cycle with low_power low then raises irq_o if R8 holds at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe for the slot dword |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data, status in 31:16, control in 15:0 |
| cfg_rd_data | output | 32 | Current status and control words |
| bind_en | input | 1 | Record bind_addr as the slot's device |
| bind_addr | input | ADDR_W | Address of the device to bind |
| evt_attach | input | 1 | Platform attach event |
| evt_detach | input | 1 | Platform detach event |
| evt_addr | input | ADDR_W | Address named by the event |
| low_power | input | 1 | Port is in a low-power state |
| msi_en | input | 1 | Message interrupt enable |
| irq_o | output | 1 | One-cycle interrupt request |
| wake_o | output | 1 | One-cycle wake request |
| rm_stb | output | 1 | One-cycle device removal strobe |
| rm_addr | output | ADDR_W | Address of the removed device |

## Verification
The assertions assume that attach and detach never arrive in the same cycle. They also assume that bind_en never coincides with a removal write. The stimulus keeps to this by driving one operation per cycle, with an idle cycle between operations. The assertions further assume that presence-detect can only fall through a removal. This follows from status writes being unable to clear bit 6, and the stimulus tries such a write on purpose.

// File: rtl/slot_hp_pkg.sv
// Shared bit positions and codes for the hot-plug slot controller.
// Assumes the conventional slot register layout that system software decodes.
package slot_hp_pkg;
    // control word fields
    localparam int C_BTN_EN   = 0;
    localparam int C_PCHG_EN  = 3;
    localparam int C_CMD_EN   = 4;
    localparam int C_HP_EN    = 5;
    localparam int C_ATTN_LO  = 6;
    localparam int C_PWR_LO   = 8;
    // status word fields
    localparam int S_BTN      = 0;
    localparam int S_PCHG     = 3;
    localparam int S_CMD      = 4;
    localparam int S_PRES     = 6;
    localparam logic [1:0]  IND_OFF   = 2'b11;
    localparam logic [15:0] STAT_W1C  = 16'h011B;
    localparam logic [15:0] CTRL_INIT = 16'(IND_OFF) << C_PWR_LO | 16'(IND_OFF) << C_ATTN_LO;
endpackage

// File: rtl/slot_hp_dev.sv
// Device binding for the slot: holds the bound address, qualifies events
// against it and emits the removal strobe. Assumes one event per cycle.
module slot_hp_dev #(
    parameter int ADDR_W    = 16,
    parameter bit SLOT_IMPL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bind_en,
    input  logic [ADDR_W-1:0] bind_addr,
    input  logic              evt_attach,
    input  logic              evt_detach,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              remove_req,
    output logic              attach_ok,
    output logic              detach_ok,
    output logic              rm_stb,
    output logic [ADDR_W-1:0] rm_addr
);
    logic              rec_valid;
    logic [ADDR_W-1:0] rec_addr;
    logic              hit;

    // event address must match the current binding
    always_comb begin
        hit       = SLOT_IMPL && rec_valid && (evt_addr == rec_addr);
        attach_ok = hit && evt_attach;
        detach_ok = hit && evt_detach;
    end

    // binding register, dropped on removal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_addr  <= '0;
        end else if (remove_req) begin
            rec_valid <= 1'b0;
        end else if (bind_en && SLOT_IMPL) begin
            rec_valid <= 1'b1;
            rec_addr  <= bind_addr;
        end
    end

    // one-cycle removal strobe carrying the removed address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_stb  <= 1'b0;
            rm_addr <= '0;
        end else begin
            rm_stb <= remove_req && rec_valid;
            if (remove_req && rec_valid) rm_addr <= rec_addr;
        end
    end
endmodule

// File: rtl/slot_hp_regs.sv
// Slot control and status registers: write decode, write-one-to-clear,
// event set bits, removal detection and interrupt qualification terms.
// Assumes event sets take priority over same-cycle clears.
module slot_hp_regs
    import slot_hp_pkg::*;
#(
    parameter bit SLOT_IMPL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        attach_ok,
    input  logic        detach_ok,
    output logic [15:0] ctrl_q,
    output logic [15:0] stat_q,
    output logic        remove_req,
    output logic        cc_fire,
    output logic        hp_qual
);
    localparam logic [15:0] CTRL_RST = SLOT_IMPL ? CTRL_INIT : 16'h0000;

    logic        ctrl_wr, stat_wr, cc_event;
    logic [15:0] ctrl_nxt, stat_nxt;

    // only full 16-bit halves are accepted
    always_comb begin
        ctrl_wr = SLOT_IMPL && wr_en && (&wr_be[1:0]);
        stat_wr = SLOT_IMPL && wr_en && (&wr_be[3:2]);
    end

    // next control value, change detection and removal detection
    always_comb begin
        ctrl_nxt   = ctrl_q;
        cc_event   = 1'b0;
        remove_req = 1'b0;
        if (ctrl_wr) begin
            ctrl_nxt   = wr_data[15:0];
            cc_event   = (wr_data[15:0] != ctrl_q);
            remove_req = stat_q[S_PRES]
                      && (wr_data[C_PWR_LO +: 2] == IND_OFF)
                      && (ctrl_q[C_PWR_LO +: 2] != IND_OFF);
        end
    end

    // next status value: clears first, then sets
    always_comb begin
        stat_nxt = stat_q;
        if (stat_wr) stat_nxt = stat_nxt & ~(wr_data[31:16] & STAT_W1C);
        if (remove_req) begin
            stat_nxt[S_PRES] = 1'b0;
            stat_nxt[S_PCHG] = 1'b1;
        end
        if (cc_event) stat_nxt[S_CMD] = 1'b1;
        if (attach_ok) begin
            stat_nxt[S_PRES] = 1'b1;
            stat_nxt[S_PCHG] = 1'b1;
            stat_nxt[S_BTN]  = 1'b1;
        end
        if (detach_ok) begin
            stat_nxt[S_PCHG] = 1'b1;
            stat_nxt[S_BTN]  = 1'b1;
        end
    end

    // interrupt qualification on the values about to be stored
    always_comb begin
        cc_fire = cc_event && ctrl_nxt[C_CMD_EN] && stat_nxt[S_CMD];
        hp_qual = ctrl_nxt[C_HP_EN]
               && ((stat_nxt[S_BTN]  && ctrl_nxt[C_BTN_EN])
                || (stat_nxt[S_PCHG] && ctrl_nxt[C_PCHG_EN]));
    end

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= 16'h0000;
        end else begin
            ctrl_q <= ctrl_nxt;
            stat_q <= stat_nxt;
        end
    end
endmodule

// File: rtl/slot_hp_irq.sv
// Interrupt request and wake generation. Defers hot-plug interrupts from
// platform events while the port is in low power and releases them on exit.
module slot_hp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cc_fire,
    input  logic hp_qual,
    input  logic remove_req,
    input  logic dev_event,
    input  logic low_power,
    input  logic msi_en,
    output logic irq_o,
    output logic wake_o
);
    logic pend_q, hp_now, pend_fire;

    // decide which hot-plug causes may fire this cycle
    always_comb begin
        hp_now    = hp_qual && (remove_req || (dev_event && !low_power));
        pend_fire = pend_q && !low_power && hp_qual;
    end

    // deferral flag, set by events in low power, cleared on exit
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (dev_event && low_power) pend_q <= 1'b1;
        else if (!low_power)             pend_q <= 1'b0;
    end

    // registered one-cycle outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= msi_en && (cc_fire || hp_now || pend_fire);
            wake_o <= dev_event && low_power;
        end
    end
endmodule

// File: rtl/slot_hp_ctrl.sv
// Top of the hot-plug slot register controller. Connects the device
// binding, the register pair and the interrupt generator.
module slot_hp_ctrl #(
    parameter int ADDR_W    = 16,
    parameter bit SLOT_IMPL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_wr_be,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              bind_en,
    input  logic [ADDR_W-1:0] bind_addr,
    input  logic              evt_attach,
    input  logic              evt_detach,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              low_power,
    input  logic              msi_en,
    output logic              irq_o,
    output logic              wake_o,
    output logic              rm_stb,
    output logic [ADDR_W-1:0] rm_addr
);
    logic        attach_ok, detach_ok, remove_req, cc_fire, hp_qual;
    logic [15:0] ctrl_q, stat_q;

    slot_hp_dev #(.ADDR_W(ADDR_W), .SLOT_IMPL(SLOT_IMPL)) u_dev (
        .clk(clk), .rst_n(rst_n), .bind_en(bind_en), .bind_addr(bind_addr),
        .evt_attach(evt_attach), .evt_detach(evt_detach), .evt_addr(evt_addr),
        .remove_req(remove_req), .attach_ok(attach_ok), .detach_ok(detach_ok),
        .rm_stb(rm_stb), .rm_addr(rm_addr)
    );

    slot_hp_regs #(.SLOT_IMPL(SLOT_IMPL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_be(cfg_wr_be),
        .wr_data(cfg_wr_data), .attach_ok(attach_ok), .detach_ok(detach_ok),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .remove_req(remove_req),
        .cc_fire(cc_fire), .hp_qual(hp_qual)
    );

    slot_hp_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cc_fire(cc_fire), .hp_qual(hp_qual),
        .remove_req(remove_req), .dev_event(attach_ok || detach_ok),
        .low_power(low_power), .msi_en(msi_en), .irq_o(irq_o), .wake_o(wake_o)
    );

    // read layout: status high, control low
    assign cfg_rd_data = {stat_q, ctrl_q};
endmodule

// File: rtl/slot_hp_chk.sv
// Assertion checker for slot_hp_ctrl, attached by bind. Assumes at most
// one platform event per cycle.
module slot_hp_chk #(
    parameter bit SLOT_IMPL = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_en,
    input logic [31:0] cfg_rd_data,
    input logic        irq_o,
    input logic        rm_stb,
    input logic        attach_ok,
    input logic        detach_ok
);
    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |=> !irq_o);
    // R5
    removal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_stb |-> (!cfg_rd_data[22] && cfg_rd_data[19]));
    // R6
    pres_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rd_data[22]) |-> rm_stb);
    // R7
    attach_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attach_ok |=> (cfg_rd_data[22] && cfg_rd_data[19] && cfg_rd_data[16]));
    // R7
    detach_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detach_ok |=> (cfg_rd_data[19] && cfg_rd_data[16]));
    // R4
    cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[15:0] != $past(cfg_rd_data[15:0])) |-> cfg_rd_data[20]);
    // R9
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(attach_ok && detach_ok));

    generate
        if (!SLOT_IMPL) begin : g_absent
            // R3
            absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_rd_data == 32'h0) && !irq_o);
        end
    endgenerate
endmodule

bind slot_hp_ctrl slot_hp_chk #(.SLOT_IMPL(SLOT_IMPL)) chk_i (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .cfg_rd_data(cfg_rd_data),
    .irq_o(irq_o), .rm_stb(rm_stb), .attach_ok(attach_ok), .detach_ok(detach_ok)
);

// File: tb/slot_hp_ctrl_tb_top.sv
module slot_hp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        bind_en = 1'b0;
    logic [15:0] bind_addr = '0;
    logic        evt_attach = 1'b0, evt_detach = 1'b0;
    logic [15:0] evt_addr = '0;
    logic        low_power = 1'b0, msi_en = 1'b1;
    logic [31:0] rd, rd_ni;
    logic        irq, wake, rm, irq_ni, wake_ni, rm_ni;
    logic [15:0] rma, rma_ni;
    int          n_vec = 0, n_bad = 0;
    logic [31:0] s_rd;
    logic        s_irq, s_wake, s_rm;

    always #4 clk = ~clk;

    slot_hp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(rd), .bind_en(bind_en),
        .bind_addr(bind_addr), .evt_attach(evt_attach), .evt_detach(evt_detach),
        .evt_addr(evt_addr), .low_power(low_power), .msi_en(msi_en),
        .irq_o(irq), .wake_o(wake), .rm_stb(rm), .rm_addr(rma)
    );

    slot_hp_ctrl #(.SLOT_IMPL(1'b0)) dut_ni (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(rd_ni), .bind_en(bind_en),
        .bind_addr(bind_addr), .evt_attach(evt_attach), .evt_detach(evt_detach),
        .evt_addr(evt_addr), .low_power(low_power), .msi_en(msi_en),
        .irq_o(irq_ni), .wake_o(wake_ni), .rm_stb(rm_ni), .rm_addr(rma_ni)
    );

    // vector: {op[1:0], be[3:0], data[31:0], exp_rd[31:0], exp_irq, exp_rm}
    // op 0 = config write, 1 = attach, 2 = detach (data[15:0] is the address)
    localparam int NV = 13;
    localparam logic [71:0] VEC [NV] = '{
        {2'd0, 4'b0011, 32'h0000_03F9, 32'h0010_03F9, 1'b1, 1'b0}, // R4 change
        {2'd0, 4'b1100, 32'h0010_0000, 32'h0000_03F9, 1'b0, 1'b0}, // R6 clear CC
        {2'd0, 4'b0011, 32'h0000_03F9, 32'h0000_03F9, 1'b0, 1'b0}, // R4 same value
        {2'd1, 4'b0000, 32'h0000_0108, 32'h0049_03F9, 1'b1, 1'b0}, // R7 R8 attach
        {2'd1, 4'b0000, 32'h0000_0109, 32'h0049_03F9, 1'b0, 1'b0}, // R9 wrong addr
        {2'd0, 4'b1100, 32'h0009_0000, 32'h0040_03F9, 1'b0, 1'b0}, // R6 W1C
        {2'd0, 4'b1100, 32'h0040_0000, 32'h0040_03F9, 1'b0, 1'b0}, // R6 PDS fixed
        {2'd0, 4'b0001, 32'h0000_0000, 32'h0040_03F9, 1'b0, 1'b0}, // R10 narrow
        {2'd0, 4'b0011, 32'h0000_01F9, 32'h0050_01F9, 1'b1, 1'b0}, // R4 PI on
        {2'd0, 4'b1100, 32'h0010_0000, 32'h0040_01F9, 1'b0, 1'b0}, // R6
        {2'd0, 4'b0011, 32'h0000_03F9, 32'h0018_03F9, 1'b1, 1'b1}, // R5 removal
        {2'd1, 4'b0000, 32'h0000_0108, 32'h0018_03F9, 1'b0, 1'b0}, // R9 unbound
        {2'd0, 4'b1100, 32'h011B_0000, 32'h0000_03F9, 1'b0, 1'b0}  // R6 all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cap();
        @(posedge clk); #1;
        s_rd = rd; s_irq = irq; s_wake = wake; s_rm = rm;
    endtask

    task automatic op(input int kind, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        case (kind)
            0: begin cfg_wr_en = 1'b1; cfg_wr_be = be; cfg_wr_data = data; end
            1: begin evt_attach = 1'b1; evt_addr = data[15:0]; end
            2: begin evt_detach = 1'b1; evt_addr = data[15:0]; end
            default: begin bind_en = 1'b1; bind_addr = data[15:0]; end
        endcase
        cap();
        @(negedge clk);
        cfg_wr_en = 1'b0; evt_attach = 1'b0; evt_detach = 1'b0; bind_en = 1'b0;
    endtask

    task automatic idle();
        cap();
    endtask

    initial begin
        #(8 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R2 reset state
        check("R2 rd", rd, 32'h0000_03C0);
        check("R2 outs", {29'd0, irq, wake, rm}, 32'h0);
        check("R3 reset rd", rd_ni, 32'h0);
        op(3, 4'b0000, 32'h0000_0108);               // R9 bind
        for (int i = 0; i < NV; i++) begin
            op(int'(VEC[i][71:70]), VEC[i][69:66], VEC[i][65:34]);
            check($sformatf("R1 vec%0d rd", i), s_rd, VEC[i][33:2]);
            check($sformatf("R11 vec%0d irq", i), {31'd0, s_irq}, {31'd0, VEC[i][1]});
            check($sformatf("R5 vec%0d rm", i), {31'd0, s_rm}, {31'd0, VEC[i][0]});
            if (VEC[i][0]) check("R5 rm_addr", {16'd0, rma}, 32'h0108);
        end
        // R7 detach sets only bits 3 and 0
        op(3, 4'b0000, 32'h0000_0220);
        op(2, 4'b0000, 32'h0000_0220);
        check("R7 detach rd", s_rd, 32'h0009_03F9);
        check("R8 detach irq", {31'd0, s_irq}, 32'd1);
        idle();
        check("R11 pulse width", {31'd0, s_irq}, 32'd0);
        // R11 msi disabled
        msi_en = 1'b0;
        op(0, 4'b0011, 32'h0000_03F8);
        check("R11 masked irq", {31'd0, s_irq}, 32'd0);
        check("R4 masked rd", s_rd, 32'h0019_03F8);
        msi_en = 1'b1;
        // R8 hot-plug enable off
        op(0, 4'b1100, 32'h011B_0000);
        op(0, 4'b0011, 32'h0000_03D8);
        op(0, 4'b1100, 32'h011B_0000);
        op(1, 4'b0000, 32'h0000_0220);
        check("R8 no hpie rd", s_rd, 32'h0049_03D8);
        check("R8 no hpie irq", {31'd0, s_irq}, 32'd0);
        op(0, 4'b0011, 32'h0000_03F8);
        op(0, 4'b1100, 32'h011B_0000);
        check("R6 pres kept", s_rd, 32'h0040_03F8);
        // R12 deferral
        low_power = 1'b1;
        op(2, 4'b0000, 32'h0000_0220);
        check("R12 irq held", {31'd0, s_irq}, 32'd0);
        check("R12 wake", {31'd0, s_wake}, 32'd1);
        check("R12 rd", s_rd, 32'h0049_03F8);
        idle();
        check("R12 wake pulse", {31'd0, s_wake}, 32'd0);
        check("R12 still held", {31'd0, s_irq}, 32'd0);
        @(negedge clk); low_power = 1'b0;
        idle();
        check("R12 release irq", {31'd0, s_irq}, 32'd1);
        // R3 absent slot
        op(0, 4'b1111, 32'h0009_03F9);
        check("R3 rd", rd_ni, 32'h0);
        op(3, 4'b0000, 32'h0000_0300);
        op(1, 4'b0000, 32'h0000_0300);
        check("R3 attach rd", rd_ni, 32'h0);
        check("R3 outs", {29'd0, irq_ni, wake_ni, rm_ni}, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule